// File: doc/BRIEF.md
# Single-Bus Register Machine Sequencer

This block is a hardwired control unit joined to a single-bus datapath for a small register machine. A step counter walks each instruction through a fixed list of steps. In every step a decoder raises the bus-gating, register-load and adder-select controls for that step. All transfers between the program counter, the memory address and data registers, the instruction register, the accumulator-style register R1, the adder's operand latch Y and its result latch Z pass over one shared bus. Each instruction begins with a three-step fetch. The fetch forms PC+4 in the adder and writes it back to both PC and Y.

Two instructions are executed. Add-immediate adds the instruction's offset field to R1. Add-direct reads the word at the byte address held in the offset field and adds it to R1. Every other opcode is retired straight after fetch, as a no-op. Memory sits outside the block. It takes a one-cycle read request and answers after a variable latency with a completion pulse. Any step that waits on memory holds until that pulse arrives. The step that ends an instruction sends the counter back to the first fetch step and produces a one-cycle done pulse, so results can be checked instruction by instruction.

Top module: `sbus_cpu`

## Requirements
- R1: While reset is held, `r1` is 0 and both `instr_done` and `mem_rd` are low. The first fetch after reset reads byte address 0.
- R2: Every instruction is fetched with a `mem_rd` pulse one cycle long, with `mem_addr` equal to PC. PC starts at 0 and grows by 4 for each instruction. The instruction word is taken from `mem_rdata[15:0]`, with the opcode in bits [15:12] and the offset in bits [11:0].
- R3: Opcode 4'h1 (add immediate) adds the zero-extended offset field to `r1`. With fetch latency d, it occupies d+6 cycles.
- R4: Opcode 4'h2 (add direct) issues a second read whose `mem_addr` is the zero-extended offset, then adds the returned word to `r1`. With fetch latency d1 and operand latency d2, it occupies d1+d2+7 cycles.
- R5: A step that waits for memory does not advance until `mem_done` is high. The memory answers 1 to 4 cycles after the cycle in which `mem_rd` is high. This stalling is what sets the cycle counts in R3, R4 and R6.
- R6: Any other opcode leaves `r1` unchanged, issues no operand read and occupies d+4 cycles. The next fetch then reads from PC+4.
- R7: No more than one source drives the shared bus in any cycle.
- R8: `instr_done` is high for exactly one cycle. That cycle is the one right after the instruction's last step, and `r1` already holds the new result in it.
- R9: Additions wrap modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | DATA_W | Byte address of the read, taken from MAR |
| mem_rd | output | 1 | One-cycle read request |
| mem_rdata | input | DATA_W | Read data, valid when mem_done is high |
| mem_done | input | 1 | Read completion pulse |
| r1 | output | DATA_W | Current value of register R1 |
| instr_done | output | 1 | One-cycle pulse after each retired instruction |

## Verification
Two things can happen on the same clock edge: a read completes, and the waiting step performs its own transfers. On that edge in fetch step 2, MDR captures the returned word while PC and Y capture Z. In add-direct step 5, MDR is loaded while Y takes R1. Each latency from 1 to 4 is used for both the fetch read and the operand read, including the case where completion arrives in the first cycle a wait step can see it. A run passes only if three things hold: the interval between done pulses matches the stall-dependent cycle count, the next fetch address is PC+4, and R1 matches a reference sum.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int LAST_STEP = 7;

  localparam int SRC_PC  = 0;
  localparam int SRC_Z   = 1;
  localparam int SRC_MDR = 2;
  localparam int SRC_R1  = 3;
  localparam int SRC_OFS = 4;
  localparam int N_SRC   = 5;

  typedef struct packed {
    logic pc_out;
    logic z_out;
    logic mdr_out;
    logic r1_out;
    logic ofs_out;
    logic pc_in;
    logic mar_in;
    logic y_in;
    logic z_in;
    logic ir_in;
    logic r1_in;
    logic rd;
    logic sel4;
    logic wmfc;
    logic fin;
  } ctrl_t;

endpackage

// File: rtl/sbus_step_seq.sv
module sbus_step_seq #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              fin,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;

  always_comb begin
    step_d = step_q;
    if (adv) begin
      if (fin) step_d = FIRST;
      else     step_d = step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= FIRST;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/sbus_ctrl_dec.sv
module sbus_ctrl_dec
  import sbus_pkg::*;
#(
  parameter int              STEP_W   = 3,
  parameter int              OPC_W    = 4,
  parameter logic [OPC_W-1:0] OPC_ADDI = 4'h1,
  parameter logic [OPC_W-1:0] OPC_ADDM = 4'h2
) (
  input  logic [STEP_W-1:0] step,
  input  logic [OPC_W-1:0]  opcode,
  output ctrl_t             ctrl
);

  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] S6 = STEP_W'(6);
  localparam logic [STEP_W-1:0] S7 = STEP_W'(7);

  logic is_imm;
  logic is_mem;

  assign is_imm = (opcode == OPC_ADDI);
  assign is_mem = (opcode == OPC_ADDM);

  always_comb begin
    ctrl = '0;
    case (step)
      // fetch: address out, PC+4 formed in the adder
      S1: begin
        ctrl.pc_out = 1'b1;
        ctrl.mar_in = 1'b1;
        ctrl.rd     = 1'b1;
        ctrl.sel4   = 1'b1;
        ctrl.z_in   = 1'b1;
      end
      // fetch: PC+4 into PC and Y, hold for memory
      S2: begin
        ctrl.z_out = 1'b1;
        ctrl.pc_in = 1'b1;
        ctrl.y_in  = 1'b1;
        ctrl.wmfc  = 1'b1;
      end
      S3: begin
        ctrl.mdr_out = 1'b1;
        ctrl.ir_in   = 1'b1;
      end
      S4: begin
        if (is_imm) begin
          ctrl.ofs_out = 1'b1;
          ctrl.y_in    = 1'b1;
        end else if (is_mem) begin
          ctrl.ofs_out = 1'b1;
          ctrl.mar_in  = 1'b1;
          ctrl.rd      = 1'b1;
        end else begin
          ctrl.fin = 1'b1;
        end
      end
      S5: begin
        if (is_imm) begin
          ctrl.r1_out = 1'b1;
          ctrl.z_in   = 1'b1;
        end else if (is_mem) begin
          ctrl.r1_out = 1'b1;
          ctrl.y_in   = 1'b1;
          ctrl.wmfc   = 1'b1;
        end else begin
          ctrl.fin = 1'b1;
        end
      end
      S6: begin
        if (is_imm) begin
          ctrl.z_out = 1'b1;
          ctrl.r1_in = 1'b1;
          ctrl.fin   = 1'b1;
        end else if (is_mem) begin
          ctrl.mdr_out = 1'b1;
          ctrl.z_in    = 1'b1;
        end else begin
          ctrl.fin = 1'b1;
        end
      end
      S7: begin
        if (is_mem) begin
          ctrl.z_out = 1'b1;
          ctrl.r1_in = 1'b1;
        end
        ctrl.fin = 1'b1;
      end
      default: ctrl.fin = 1'b1;
    endcase
  end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter int OFS_W   = 12,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  bus_src,
  input  logic              ld_pc,
  input  logic              ld_mar,
  input  logic              ld_y,
  input  logic              ld_z,
  input  logic              ld_ir,
  input  logic              ld_r1,
  input  logic              sel4,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] mar_o,
  output logic [DATA_W-1:0] r1_o
);

  localparam int PAD_W = DATA_W - OFS_W;

  logic [DATA_W-1:0]  pc_q, mar_q, mdr_q, y_q, z_q, r1_q;
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  src_val [N_SRC];
  logic [DATA_W-1:0]  bus;
  logic [DATA_W-1:0]  alu_a;
  logic [DATA_W-1:0]  sum;

  assign src_val[SRC_PC]  = pc_q;
  assign src_val[SRC_Z]   = z_q;
  assign src_val[SRC_MDR] = mdr_q;
  assign src_val[SRC_R1]  = r1_q;
  assign src_val[SRC_OFS] = {{PAD_W{1'b0}}, ir_q[OFS_W-1:0]};

  // AND-OR bus: each source gated by its one-hot enable
  always_comb begin
    bus = '0;
    for (int i = 0; i < N_SRC; i++) begin
      bus = bus | (src_val[i] & {DATA_W{bus_src[i]}});
    end
  end

  assign alu_a = sel4 ? DATA_W'(PC_STEP) : y_q;
  assign sum   = alu_a + bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (ld_pc) pc_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mar_q <= '0;
    else if (ld_mar) mar_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mdr_q <= '0;
    else if (mem_done) mdr_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    y_q <= '0;
    else if (ld_y) y_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    z_q <= '0;
    else if (ld_z) z_q <= sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ld_ir) ir_q <= bus[INSTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r1_q <= '0;
    else if (ld_r1) r1_q <= bus;
  end

  assign opcode = ir_q[INSTR_W-1 -: OPC_W];
  assign mar_o  = mar_q;
  assign r1_o   = r1_q;

endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
  import sbus_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              INSTR_W  = 16,
  parameter int              OPC_W    = 4,
  parameter int              OFS_W    = 12,
  parameter int              PC_STEP  = 4,
  parameter logic [OPC_W-1:0] OPC_ADDI = 4'h1,
  parameter logic [OPC_W-1:0] OPC_ADDM = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic [DATA_W-1:0] r1,
  output logic              instr_done
);

  localparam int STEP_W = $clog2(LAST_STEP + 1);

  ctrl_t             ctrl;
  logic              adv;
  logic [STEP_W-1:0] step;
  logic [OPC_W-1:0]  opcode;
  logic [N_SRC-1:0]  bus_src;
  logic              rd_q;
  logic              done_q;

  // a waiting step holds until memory completes
  assign adv = ~(ctrl.wmfc & ~mem_done);

  always_comb begin
    bus_src          = '0;
    bus_src[SRC_PC]  = ctrl.pc_out;
    bus_src[SRC_Z]   = ctrl.z_out;
    bus_src[SRC_MDR] = ctrl.mdr_out;
    bus_src[SRC_R1]  = ctrl.r1_out;
    bus_src[SRC_OFS] = ctrl.ofs_out;
  end

  sbus_step_seq #(
    .STEP_W (STEP_W)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .fin   (ctrl.fin),
    .step  (step)
  );

  sbus_ctrl_dec #(
    .STEP_W   (STEP_W),
    .OPC_W    (OPC_W),
    .OPC_ADDI (OPC_ADDI),
    .OPC_ADDM (OPC_ADDM)
  ) u_dec (
    .step   (step),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  sbus_datapath #(
    .DATA_W  (DATA_W),
    .INSTR_W (INSTR_W),
    .OPC_W   (OPC_W),
    .OFS_W   (OFS_W),
    .PC_STEP (PC_STEP)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_src   (bus_src),
    .ld_pc     (ctrl.pc_in  & adv),
    .ld_mar    (ctrl.mar_in & adv),
    .ld_y      (ctrl.y_in   & adv),
    .ld_z      (ctrl.z_in   & adv),
    .ld_ir     (ctrl.ir_in  & adv),
    .ld_r1     (ctrl.r1_in  & adv),
    .sel4      (ctrl.sel4),
    .mem_rdata (mem_rdata),
    .mem_done  (mem_done),
    .opcode    (opcode),
    .mar_o     (mem_addr),
    .r1_o      (r1)
  );

  // request goes out the cycle after MAR is loaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= ctrl.rd & adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= ctrl.fin & adv;
  end

  assign mem_rd     = rd_q;
  assign instr_done = done_q;

endmodule

// File: rtl/sbus_cpu_chk.sv
module sbus_cpu_chk
  import sbus_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  bus_src,
  input logic [STEP_W-1:0] step,
  input logic              wmfc,
  input logic              fin,
  input logic              mem_done,
  input logic              mem_rd,
  input logic              instr_done
);

  assert_single_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_src));

  assert_hold_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc && !mem_done) |=> $stable(step));

  assert_leave_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc && mem_done) |=> (step != $past(step)));

  assert_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (step == STEP_W'(1)));

  assert_done_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> instr_done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

endmodule

bind sbus_cpu sbus_cpu_chk #(.STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_src    (bus_src),
  .step       (step),
  .wmfc       (ctrl.wmfc),
  .fin        (ctrl.fin),
  .mem_done   (mem_done),
  .mem_rd     (mem_rd),
  .instr_done (instr_done)
);

// File: tb/sbus_cpu_tb.sv
module sbus_cpu_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic [31:0] mem_rdata;
  logic        mem_done;
  logic [31:0] r1;
  logic        instr_done;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] mem [64];
  int          fetch_lat, op_lat;
  int          busy, cntdn, cyc, nrd;
  logic [31:0] addr_l, rd_a, rd_b;
  int          seen_len, seen_nrd;
  logic [31:0] pc_ref, r1_ref;
  bit          len_valid;

  sbus_cpu u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_rdata  (mem_rdata),
    .mem_done   (mem_done),
    .r1         (r1),
    .instr_done (instr_done)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // memory model and interval monitor, all at the falling edge
  initial begin
    mem_done  = 1'b0;
    mem_rdata = '0;
    busy = 0; cntdn = 0; cyc = 0; nrd = 0;
    forever begin
      @(negedge clk);
      mem_done = 1'b0;
      if (!rst_n) begin
        busy = 0; cyc = 0; nrd = 0;
      end else begin
        cyc++;
        if (busy != 0) begin
          cntdn--;
          if (cntdn == 0) begin
            busy      = 0;
            mem_done  = 1'b1;
            mem_rdata = mem[addr_l[7:2]];
          end
        end
        if (mem_rd) begin
          addr_l = mem_addr;
          busy   = 1;
          cntdn  = (nrd == 0) ? fetch_lat : op_lat;
          if (nrd == 0) rd_a = mem_addr;
          else          rd_b = mem_addr;
          nrd++;
        end
        if (instr_done) begin
          seen_len = cyc;
          seen_nrd = nrd;
          cyc = 0;
          nrd = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one instruction placed at the reference PC and judge its results
  task automatic run_one(input logic [15:0] word, input int fl, input int ol,
                         input logic [31:0] exp_r1, input int exp_len,
                         input int exp_nrd, input logic [31:0] exp_opa,
                         input string tag);
    int w;
    mem[pc_ref[7:2]] = {16'h0, word};
    fetch_lat = fl;
    op_lat    = ol;
    w = 0;
    do begin
      @(negedge clk);
      #1;
      w++;
    end while (!instr_done && w < 200);
    if (!instr_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 %s: actual=hung expected=instr_done", tag);
    end else begin
      // r1 is already updated in the done cycle (R8); a second bus driver would corrupt it (R7)
      chk({tag, " R8 R7 result"}, r1, exp_r1);
      chk({"R2 fetch address ", tag}, rd_a, pc_ref);
      chk({"R6 read count ", tag}, 32'(seen_nrd), 32'(exp_nrd));
      if (exp_nrd == 2) chk({"R4 operand address ", tag}, rd_b, exp_opa);
      if (len_valid) chk({"R5 cycle count ", tag}, 32'(seen_len), 32'(exp_len));
    end
    len_valid = 1'b1;
    r1_ref    = exp_r1;
    pc_ref    = pc_ref + 32'd4;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 r1 in reset", r1, 32'h0);
    chk("R1 instr_done in reset", {31'h0, instr_done}, 32'h0);
    chk("R1 mem_rd in reset", {31'h0, mem_rd}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_add_imm();
    // opcode 4'h1: d+6 cycles; first fetch must hit address 0 (R1)
    run_one(16'h1005, 1, 1, r1_ref + 32'h5,   7, 1, 32'h0, "R3 R1 imm 5");
    run_one(16'h10A0, 3, 1, r1_ref + 32'hA0,  9, 1, 32'h0, "R3 imm A0");
    run_one(16'h1FFF, 4, 1, r1_ref + 32'hFFF, 10, 1, 32'h0, "R3 imm FFF zero-ext");
    run_one(16'h1000, 2, 1, r1_ref,           8, 1, 32'h0, "R3 imm 0");
  endtask

  task automatic test_add_mem();
    mem[32] = 32'h1234_5678;
    run_one(16'h2080, 1, 1, r1_ref + 32'h1234_5678, 9, 2, 32'h80, "R4 direct 80");
    mem[63] = 32'h0000_1000;
    run_one(16'h20FC, 4, 2, r1_ref + 32'h1000, 13, 2, 32'hFC, "R4 direct FC");
    mem[48] = 32'h7;
    run_one(16'h20C0, 2, 4, r1_ref + 32'h7, 13, 2, 32'hC0, "R4 direct C0");
    mem[49] = 32'hDEAD_0001;
    run_one(16'h20C4, 3, 3, r1_ref + 32'hDEAD_0001, 13, 2, 32'hC4, "R4 direct C4");
  endtask

  task automatic test_unknown_op();
    run_one(16'h0123, 1, 1, r1_ref, 5, 1, 32'h0, "R6 opcode 0");
    run_one(16'h7ABC, 3, 1, r1_ref, 7, 1, 32'h0, "R6 opcode 7");
    run_one(16'hF080, 2, 1, r1_ref, 6, 1, 32'h0, "R6 opcode F");
    // next fetch continues at PC+4 after the no-ops
    run_one(16'h1001, 1, 1, r1_ref + 32'h1, 7, 1, 32'h0, "R6 R3 after no-op");
  endtask

  task automatic test_wraparound();
    mem[36] = ~r1_ref + 32'd2;
    run_one(16'h2090, 2, 1, 32'h1, 10, 2, 32'h90, "R9 wrap to 1");
    mem[37] = 32'hFFFF_FFFF;
    run_one(16'h2094, 1, 2, 32'h0, 10, 2, 32'h94, "R9 wrap to 0");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    pc_ref = '0; r1_ref = '0; len_valid = 1'b0;
    fetch_lat = 1; op_lat = 1;
    test_reset();
    test_add_imm();
    test_add_mem();
    test_unknown_op();
    test_wraparound();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule